// File: doc/BRIEF.md
# Floating-Point Sign Operations and NaN Classifier

This block is a small slice of a floating-point unit. It works on single-precision (32-bit) and double-precision (64-bit) operands. It performs absolute value and negation, reports whether an operand is a signaling or a quiet NaN, and produces the default NaN pattern. Two bits of a local control/status register set its behaviour while it runs.

The first control bit selects the NaN encoding. In legacy encoding, a set top fraction bit marks a signaling NaN. In 2008 encoding, a clear top fraction bit marks a signaling NaN. The second control bit decides how the sign operations treat NaNs. When it is clear, absolute value and negation are arithmetic: a NaN operand raises the invalid flag and yields the default NaN. When it is set, both operations only change the sign bit.

Software writes the control register through a port. Only the bits that are set in a build-time writable mask can change. Reads always return the whole register.

Each request takes one cycle. The registered result appears in the next cycle and is marked valid.

Top module: `fpsn_unit`

## Requirements
- R1: After reset the control register reads 0 (legacy encoding, arithmetic sign operations). Also after reset, `res_valid`, `res_value`, `res_invalid`, `res_snan` and `res_qnan` are all 0.
- R2: A control write changes only the bits set in `CSR_WMASK` (default 32'h010C_0F7F). All other bits keep their value. The new value is readable on `csr_rdata` in the cycle after the write. The NaN encoding bit is bit 18 and the sign-mode bit is bit 19.
- R3: A request with `req_valid` high gives `res_valid` high with its result in the next cycle. A cycle with no request gives `res_valid` low and `res_value` 0 in the next cycle.
- R4: In legacy encoding (bit 18 = 0), a NaN operand with fraction MSB = 1 gives `res_snan`=1. A NaN operand with fraction MSB = 0 gives `res_qnan`=1. A NaN has an all-ones exponent and a nonzero fraction. The fraction MSB is bit 22 for single precision and bit 51 for double precision.
- R5: In 2008 encoding (bit 18 = 1), a NaN operand with fraction MSB = 0 gives `res_snan`=1. A NaN operand with fraction MSB = 1 gives `res_qnan`=1.
- R6: Infinities (all-ones exponent, zero fraction) and all other non-NaN operands give `res_snan`=0 and `res_qnan`=0. `res_snan` and `res_qnan` are never both 1.
- R7: With bit 19 = 1, ABS (`req_op`=0) clears the sign bit and NEG (`req_op`=1) flips it, for every operand including NaNs, with `res_invalid`=0. In single precision (`req_dbl`=0) the sign bit is bit 31, operand bits 63:32 are ignored and result bits 63:32 are 0. In double precision the sign bit is bit 63.
- R8: With bit 19 = 0 and a non-NaN operand, ABS and NEG behave as in R7 with `res_invalid`=0.
- R9: With bit 19 = 0 and a NaN operand, ABS and NEG return the default NaN of the current encoding and raise `res_invalid`.
- R10: DNAN (`req_op`=3) returns the default NaN:
  - legacy encoding: 32'h7FBFFFFF (single) and 64'h7FF7FFFFFFFFFFFF (double);
  - 2008 encoding: 32'h7FC00000 (single) and 64'h7FF8000000000000 (double).
  
  CLASS (`req_op`=2) returns value 0 with `res_invalid`=0. Every operation reports the operand class on `res_snan` and `res_qnan`.
- R11: A request made in the same cycle as a control write uses the control value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Operation request strobe |
| req_op | input | 2 | 0 ABS, 1 NEG, 2 CLASS, 3 DNAN |
| req_dbl | input | 1 | 1 double precision, 0 single precision |
| req_operand | input | 64 | Operand; single precision uses bits 31:0 |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_value | output | 64 | Result value |
| res_invalid | output | 1 | Invalid-operation flag |
| res_snan | output | 1 | Operand is a signaling NaN |
| res_qnan | output | 1 | Operand is a quiet NaN |
| csr_we | input | 1 | Control register write strobe |
| csr_wdata | input | 32 | Control register write data |
| csr_rdata | output | 32 | Current control register value |

## Verification
The operand sweep builds every operand from these parts:
- an exponent of zero, one, mid-range, one below all-ones, or all-ones;
- a fraction of zero, one LSB, only the quiet bit, the quiet bit plus LSB, or all ones;
- both sign values.

This mix separates infinities from NaNs, and NaNs whose quiet bit is the only set fraction bit from NaNs whose quiet bit is clear. The sweep runs every operation in all four combinations of the two control bits, for both precisions. It therefore shows whether the encoding bit flips the signaling/quiet decision, and whether the sign-mode bit switches between the arithmetic path and the sign-only path. Single-precision operands carry junk in their upper half, which catches leakage from the unused half. The control-register writes use all-ones, all-zeros and mixed patterns against the mask. One write is issued together with a request, which shows whether the request uses the old or the new mode.

// File: rtl/fpsn_pkg.sv
package fpsn_pkg;

    localparam int unsigned FPSN_DW    = 64;
    localparam int unsigned FPSN_NPREC = 2;

    typedef enum logic [1:0] {
        OP_ABS   = 2'd0,
        OP_NEG   = 2'd1,
        OP_CLASS = 2'd2,
        OP_DNAN  = 2'd3
    } fpsn_op_e;

    typedef struct packed {
        logic is_nan;
        logic snan;
        logic qnan;
    } fpsn_cls_t;

    typedef struct packed {
        logic               valid;
        logic [FPSN_DW-1:0] value;
        logic               invalid;
        logic               snan;
        logic               qnan;
    } fpsn_res_t;

    // precision index: 0 single, 1 double
    function automatic int unsigned fpsn_exp_w(input int unsigned p);
        return (p == 0) ? 8 : 11;
    endfunction

    function automatic int unsigned fpsn_frac_w(input int unsigned p);
        return (p == 0) ? 23 : 52;
    endfunction

    function automatic logic [FPSN_DW-1:0] fpsn_dnan(input logic dbl, input logic n2008);
        logic [FPSN_DW-1:0] v;
        if (dbl)
            v = n2008 ? 64'h7FF8_0000_0000_0000 : 64'h7FF7_FFFF_FFFF_FFFF;
        else
            v = n2008 ? 64'h0000_0000_7FC0_0000 : 64'h0000_0000_7FBF_FFFF;
        return v;
    endfunction

endpackage

// File: rtl/fpsn_csr.sv
module fpsn_csr #(
    parameter int unsigned     W     = 32,
    parameter logic [W-1:0]    WMASK = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] rdata
);

    logic [W-1:0] csr_d, csr_q;

    always_comb begin
        csr_d = csr_q;
        if (we) begin
            csr_d = (csr_q & ~WMASK) | (wdata & WMASK);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            csr_q <= '0;
        end else begin
            csr_q <= csr_d;
        end
    end

    assign rdata = csr_q;

endmodule

// File: rtl/fpsn_classify.sv
module fpsn_classify
    import fpsn_pkg::*;
#(
    parameter int unsigned EXP_W  = 8,
    parameter int unsigned FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W-1:0] bits,
    input  logic                    n2008,
    output fpsn_cls_t               cls
);

    localparam int unsigned TOP = EXP_W + FRAC_W - 1;

    logic exp_ones;
    logic frac_nz;
    logic quiet_bit;

    always_comb begin
        exp_ones   = &bits[TOP:FRAC_W];
        frac_nz    = |bits[FRAC_W-1:0];
        quiet_bit  = bits[FRAC_W-1];
        cls.is_nan = exp_ones & frac_nz;
        // legacy: top fraction bit set means signaling; 2008: clear means signaling
        cls.snan   = cls.is_nan & (n2008 ? ~quiet_bit : quiet_bit);
        cls.qnan   = cls.is_nan & ~cls.snan;
    end

endmodule

// File: rtl/fpsn_signop.sv
module fpsn_signop
    import fpsn_pkg::*;
(
    input  fpsn_op_e           op,
    input  logic               dbl,
    input  logic [FPSN_DW-1:0] x,
    input  logic               is_nan,
    input  logic               a2008,
    input  logic [FPSN_DW-1:0] dnan,
    output logic [FPSN_DW-1:0] value,
    output logic               invalid
);

    logic [FPSN_DW-1:0] xm;
    logic [FPSN_DW-1:0] sbit;
    logic               arith_nan;

    always_comb begin
        xm        = dbl ? x : {32'h0, x[31:0]};
        sbit      = dbl ? {1'b1, 63'h0} : {32'h0, 1'b1, 31'h0};
        arith_nan = ~a2008 & is_nan;
        value     = '0;
        invalid   = 1'b0;
        unique case (op)
            OP_ABS, OP_NEG: begin
                if (arith_nan) begin
                    value   = dnan;
                    invalid = 1'b1;
                end else if (op == OP_ABS) begin
                    value = xm & ~sbit;
                end else begin
                    value = xm ^ sbit;
                end
            end
            OP_CLASS: value = '0;
            OP_DNAN:  value = dnan;
            default:  value = '0;
        endcase
    end

endmodule

// File: rtl/fpsn_unit.sv
module fpsn_unit
    import fpsn_pkg::*;
#(
    parameter int unsigned         CSR_W        = 32,
    parameter logic [CSR_W-1:0]    CSR_WMASK    = 32'h010C_0F7F,
    parameter int unsigned         NAN_MODE_POS = 18,
    parameter int unsigned         ABS_MODE_POS = 19
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_op,
    input  logic               req_dbl,
    input  logic [FPSN_DW-1:0] req_operand,
    output logic               res_valid,
    output logic [FPSN_DW-1:0] res_value,
    output logic               res_invalid,
    output logic               res_snan,
    output logic               res_qnan,
    input  logic               csr_we,
    input  logic [CSR_W-1:0]   csr_wdata,
    output logic [CSR_W-1:0]   csr_rdata
);

    logic [CSR_W-1:0]   csr_q;
    logic               n2008;
    logic               a2008;
    fpsn_cls_t          cls_prec [FPSN_NPREC];
    fpsn_cls_t          cls_sel;
    logic [FPSN_DW-1:0] dnan;
    logic [FPSN_DW-1:0] sop_val;
    logic               sop_inv;
    fpsn_res_t          res_d, res_q;

    fpsn_csr #(
        .W     (CSR_W),
        .WMASK (CSR_WMASK)
    ) u_csr (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (csr_we),
        .wdata (csr_wdata),
        .rdata (csr_q)
    );

    assign csr_rdata = csr_q;
    assign n2008     = csr_q[NAN_MODE_POS];
    assign a2008     = csr_q[ABS_MODE_POS];

    for (genvar p = 0; p < FPSN_NPREC; p++) begin : g_prec
        localparam int unsigned EW = fpsn_exp_w(p);
        localparam int unsigned FW = fpsn_frac_w(p);
        fpsn_classify #(
            .EXP_W  (EW),
            .FRAC_W (FW)
        ) u_cls (
            .bits  (req_operand[EW+FW-1:0]),
            .n2008 (n2008),
            .cls   (cls_prec[p])
        );
    end

    assign cls_sel = req_dbl ? cls_prec[1] : cls_prec[0];
    assign dnan    = fpsn_dnan(req_dbl, n2008);

    fpsn_signop u_sop (
        .op      (fpsn_op_e'(req_op)),
        .dbl     (req_dbl),
        .x       (req_operand),
        .is_nan  (cls_sel.is_nan),
        .a2008   (a2008),
        .dnan    (dnan),
        .value   (sop_val),
        .invalid (sop_inv)
    );

    always_comb begin
        res_d = '0;
        if (req_valid) begin
            res_d.valid   = 1'b1;
            res_d.value   = sop_val;
            res_d.invalid = sop_inv;
            res_d.snan    = cls_sel.snan;
            res_d.qnan    = cls_sel.qnan;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign res_valid   = res_q.valid;
    assign res_value   = res_q.value;
    assign res_invalid = res_q.invalid;
    assign res_snan    = res_q.snan;
    assign res_qnan    = res_q.qnan;

endmodule

// File: rtl/fpsn_unit_chk.sv
module fpsn_unit_chk #(
    parameter int unsigned      CSR_W        = 32,
    parameter logic [CSR_W-1:0] CSR_WMASK    = 32'h010C_0F7F,
    parameter int unsigned      ABS_MODE_POS = 19
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [1:0]       req_op,
    input logic             res_valid,
    input logic             res_invalid,
    input logic             res_snan,
    input logic             res_qnan,
    input logic             csr_we,
    input logic [CSR_W-1:0] csr_wdata,
    input logic [CSR_W-1:0] csr_rdata
);

    AST_CSR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        csr_we |=> ((csr_rdata & ~CSR_WMASK) == ($past(csr_rdata) & ~CSR_WMASK))); // R2
    AST_CSR_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        csr_we |=> ((csr_rdata & CSR_WMASK) == ($past(csr_wdata) & CSR_WMASK))); // R2
    AST_CSR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !csr_we |=> $stable(csr_rdata)); // R2
    AST_RES_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid); // R3
    AST_RES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !res_valid); // R3
    AST_CLASS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_snan && res_qnan)); // R6
    AST_SIGN_NOFLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_op[1] && csr_rdata[ABS_MODE_POS]) |=> !res_invalid); // R7
    AST_INV_NAN: assert property (@(posedge clk) disable iff (!rst_n)
        res_invalid |-> (res_snan || res_qnan)); // R9

endmodule

bind fpsn_unit fpsn_unit_chk #(
    .CSR_W        (CSR_W),
    .CSR_WMASK    (CSR_WMASK),
    .ABS_MODE_POS (ABS_MODE_POS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .res_valid   (res_valid),
    .res_invalid (res_invalid),
    .res_snan    (res_snan),
    .res_qnan    (res_qnan),
    .csr_we      (csr_we),
    .csr_wdata   (csr_wdata),
    .csr_rdata   (csr_rdata)
);

// File: tb/fpsn_unit_bench.sv
module fpsn_unit_bench;

    localparam int          CLK_PERIOD = 10;
    localparam logic [31:0] MASK       = 32'h010C_0F7F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'd0;
    logic        req_dbl = 1'b0;
    logic [63:0] req_operand = '0;
    logic        res_valid, res_invalid, res_snan, res_qnan;
    logic [63:0] res_value;
    logic        csr_we = 1'b0;
    logic [31:0] csr_wdata = '0;
    logic [31:0] csr_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpsn_unit u_fpsn_unit (
        .clk, .rst_n, .req_valid, .req_op, .req_dbl, .req_operand,
        .res_valid, .res_value, .res_invalid, .res_snan, .res_qnan,
        .csr_we, .csr_wdata, .csr_rdata
    );

    function automatic void model(input logic [1:0] op, input logic dbl, input logic [63:0] x,
                                  input logic n, input logic a,
                                  output logic [63:0] v, output logic inv,
                                  output logic sn, output logic qn);
        logic nan, qb;
        logic [63:0] dn, xm, sb;
        nan = dbl ? ((x[62:52] == 11'h7FF) && (x[51:0] != 0))
                  : ((x[30:23] == 8'hFF) && (x[22:0] != 0));
        qb  = dbl ? x[51] : x[22];
        sn  = nan && (n ? !qb : qb);
        qn  = nan && !sn;
        dn  = dbl ? (n ? 64'h7FF8000000000000 : 64'h7FF7FFFFFFFFFFFF)
                  : (n ? 64'h7FC00000 : 64'h7FBFFFFF);
        xm  = dbl ? x : {32'h0, x[31:0]};
        sb  = dbl ? 64'h8000000000000000 : 64'h80000000;
        inv = 1'b0;
        case (op)
            2'd0, 2'd1: begin
                if (!a && nan) begin v = dn; inv = 1'b1; end
                else v = (op == 2'd0) ? (xm & ~sb) : (xm ^ sb);
            end
            2'd2: v = '0;
            default: v = dn;
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] av, input logic [63:0] ev);
        checks++;
        if (av !== ev) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, av, ev);
        end
    endtask

    task automatic csr_write(input logic [31:0] w);
        logic [31:0] old;
        old = csr_rdata;
        @(negedge clk);
        csr_we = 1'b1; csr_wdata = w;
        @(negedge clk);
        csr_we = 1'b0;
        check("R2 csr masked write", {32'h0, csr_rdata}, {32'h0, (old & ~MASK) | (w & MASK)});
    endtask

    task automatic run_op(input logic [1:0] op, input logic dbl, input logic [63:0] x,
                          input logic n, input logic a);
        logic [63:0] ev;
        logic ei, es, eq;
        string tag;
        model(op, dbl, x, n, a, ev, ei, es, eq);
        if (op == 2'd2) tag = n ? "R5 classify 2008 / R6" : "R4 classify legacy / R6";
        else if (op == 2'd3) tag = "R10 default nan";
        else if (a) tag = "R7 sign-only";
        else tag = (es || eq) ? "R9 arithmetic nan" : "R8 arithmetic non-nan";
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_dbl = dbl; req_operand = x;
        @(negedge clk);
        req_valid = 1'b0;
        check({tag, " {valid,inv,snan,qnan} R3"},
              {60'h0, res_valid, res_invalid, res_snan, res_qnan}, {60'h0, 1'b1, ei, es, eq});
        check({tag, " value"}, res_value, ev);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [10:0] exps [5];
        logic [51:0] fracs [5];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 csr reset", {32'h0, csr_rdata}, 64'h0);
        check("R1 result reset", {59'h0, res_valid, res_invalid, res_snan, res_qnan, 1'b0}, 64'h0);
        check("R1 value reset", res_value, 64'h0);

        // R2 mask behaviour
        csr_write(32'hFFFF_FFFF);
        csr_write(32'h0000_0000);
        csr_write(32'hA5A5_5A5A);
        csr_write(32'h0000_0000);

        // R3 idle cycle after a request
        run_op(2'd3, 1'b0, 64'h0, 1'b0, 1'b0);
        @(negedge clk);
        check("R3 idle valid low", {63'h0, res_valid}, 64'h0);
        check("R3 idle value zero", res_value, 64'h0);

        // sweep
        for (int p = 0; p < 2; p++) begin
            for (int m = 0; m < 4; m++) begin
                logic n, a;
                n = m[0]; a = m[1];
                csr_write({12'hF0F, a, n, 18'h0});
                if (p == 0) begin
                    exps  = '{11'h0, 11'h1, 11'h7F, 11'hFE, 11'hFF};
                    fracs = '{52'h0, 52'h1, 52'h400000, 52'h400001, 52'h7FFFFF};
                end else begin
                    exps  = '{11'h0, 11'h1, 11'h3FF, 11'h7FE, 11'h7FF};
                    fracs = '{52'h0, 52'h1, 52'h8000000000000, 52'h8000000000001, 52'hFFFFFFFFFFFFF};
                end
                for (int e = 0; e < 5; e++) begin
                    for (int f = 0; f < 5; f++) begin
                        for (int s = 0; s < 2; s++) begin
                            logic [63:0] x;
                            if (p == 0) x = {32'hDEADBEEF, s[0], exps[e][7:0], fracs[f][22:0]};
                            else        x = {s[0], exps[e], fracs[f]};
                            for (int op = 0; op < 4; op++) begin
                                run_op(op[1:0], p[0], x, n, a);
                            end
                        end
                    end
                end
            end
        end

        // R11 request alongside a write uses the old mode
        csr_write(32'h0);
        @(negedge clk);
        csr_we = 1'b1; csr_wdata = 32'h0004_0000;
        req_valid = 1'b1; req_op = 2'd3; req_dbl = 1'b0; req_operand = '0;
        @(negedge clk);
        csr_we = 1'b0; req_valid = 1'b0;
        check("R11 same-cycle write uses old mode", res_value, 64'h7FBFFFFF);
        run_op(2'd3, 1'b0, 64'h0, 1'b1, 1'b0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule